// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

The controller sits between a simple synchronous host port and an asynchronous static RAM. The RAM has a low-active and a high-active chip enable, an output enable, a write enable, an address bus and a data bus. Each host request becomes a strobe sequence. Every phase of that sequence lasts a whole number of clock cycles. The phase lengths come from the minimum timings of the selected speed grade (15, 20, 25 or 35 ns) and the clock period. Each length is the ceiling of time over period, with a floor of one cycle.

A write opens by pulling write enable low while both chip enables are active. The controller starts driving the data bus only after the memory's output turn-off time has passed. Write enable rises first. The enables stay active for at least one more cycle, so that write enable's edge is the one that ends the write.

A read holds output enable low for the access time, samples the bus on the edge that closes the access, and registers the result with a one-cycle valid pulse. The data bus is split into an output value, an output-enable qualifier and an input, so the tri-state buffer sits outside the block.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is asserted and directly after it, the outputs hold these values: sram_ce1_no=1, sram_ce2_o=0, sram_oe_no=1, sram_we_no=1, sram_dq_oe_o=0, ready_o=1 and rvalid_o=0.
- R2: A request is taken only on a clock edge where ready_o is high. A request presented while ready_o is low has no effect on the memory or on the current access.
- R3: sram_we_no is low only while sram_ce1_no is low and sram_ce2_o is high. Both enables are still active in the cycle after sram_we_no rises.
- R4: A write holds sram_we_no low for WE_CYC cycles. WE_CYC is the largest of three values: ceil(pulse width), ceil(address-to-end) and ceil(turn-off)+ceil(data setup). With a 10 ns clock at grade 15 it is 2.
- R5: sram_dq_oe_o stays low in the first HZ_CYC cycles after sram_we_no falls (1 at the defaults). It is never high while sram_oe_no is low. The written data is driven for at least ceil(data setup) cycles before sram_we_no rises.
- R6: sram_oe_no stays high for the whole time sram_we_no is low.
- R7: A read holds sram_oe_no low for RD_CYC cycles. RD_CYC is the largest of ceil(access from address), ceil(access from output enable) and ceil(read cycle); it is 2 at the defaults. The bus is sampled on the edge that ends the access. rdata_o is then valid while rvalid_o is high, and rvalid_o is high for exactly one cycle.
- R8: After a write is accepted, ready_o stays low for WE_CYC+END_CYC cycles. END_CYC is max(1, ceil(write cycle)-WE_CYC), so the whole write spans at least the write cycle time. At the defaults ready_o is low for 3 cycles.
- R9: After a read is accepted, ready_o stays low for RD_CYC cycles. It is high again in the cycle where rvalid_o is high.
- R10: sram_addr_o does not change while the chip enables stay active from one cycle to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Host address |
| wdata_i | input | DATA_W | Host write data |
| ready_o | output | 1 | Controller idle, request can be taken |
| rdata_o | output | DATA_W | Captured read data |
| rvalid_o | output | 1 | One-cycle read data valid |
| sram_addr_o | output | ADDR_W | Memory address |
| sram_ce1_no | output | 1 | Chip enable, active low |
| sram_ce2_o | output | 1 | Chip enable, active high |
| sram_oe_no | output | 1 | Output enable, active low |
| sram_we_no | output | 1 | Write enable, active low |
| sram_dq_o | output | DATA_W | Data driven to memory |
| sram_dq_oe_o | output | 1 | Controller drives data bus |
| sram_dq_i | input | DATA_W | Data bus as seen at the pins |

## Verification
The hardest case to reach is bus ownership changing hands between a read that has just finished and a write that starts on the very next accepted edge. The memory may still be driving the bus at the moment the controller's write enable falls. The bench issues reads and writes back to back, with no idle cycle between them. Its memory model flags any cycle in which both sides drive the bus. It also returns corrupted data until output enable has been low long enough, so a read that samples one cycle too early shows up in the scoreboard.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_WR, ST_WEND, ST_RD} state_e;

  typedef struct packed {
    int unsigned wc;   // write cycle
    int unsigned pwe;  // write strobe width
    int unsigned aw;   // address valid to write end
    int unsigned sd;   // data valid to write end
    int unsigned rc;   // read cycle
    int unsigned aa;   // address to data
    int unsigned doe;  // output enable to data
    int unsigned hz;   // worst memory turn-off
  } grade_t;

  function automatic grade_t grade_times(int unsigned speed_ns);
    case (speed_ns)
      20:      return '{wc: 20, pwe: 15, aw: 15, sd: 10, rc: 20, aa: 20, doe: 9,  hz: 8};
      25:      return '{wc: 25, pwe: 15, aw: 20, sd: 10, rc: 25, aa: 25, doe: 12, hz: 10};
      35:      return '{wc: 35, pwe: 20, aw: 25, sd: 12, rc: 35, aa: 35, doe: 15, hz: 10};
      default: return '{wc: 15, pwe: 12, aw: 12, sd: 8,  rc: 15, aa: 15, doe: 8,  hz: 7};
    endcase
  endfunction

  function automatic int unsigned ns2cyc(int unsigned t_ns, int unsigned clk_ns);
    int unsigned c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned we_cycles(grade_t g, int unsigned clk_ns);
    return max2(max2(ns2cyc(g.pwe, clk_ns), ns2cyc(g.aw, clk_ns)),
                ns2cyc(g.hz, clk_ns) + ns2cyc(g.sd, clk_ns));
  endfunction

  function automatic int unsigned end_cycles(grade_t g, int unsigned clk_ns);
    int unsigned wc, we;
    wc = ns2cyc(g.wc, clk_ns);
    we = we_cycles(g, clk_ns);
    return (wc > we + 1) ? wc - we : 1;
  endfunction

  function automatic int unsigned rd_cycles(grade_t g, int unsigned clk_ns);
    return max2(max2(ns2cyc(g.aa, clk_ns), ns2cyc(g.doe, clk_ns)), ns2cyc(g.rc, clk_ns));
  endfunction

endpackage

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned WE_CYC  = 2,
  parameter int unsigned END_CYC = 1,
  parameter int unsigned RD_CYC  = 2,
  parameter int unsigned HZ_CYC  = 1,
  parameter int unsigned CNT_W   = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic we_i,
  output logic ready_o,
  output logic load_o,
  output logic capture_o,
  output logic ce_o,
  output logic oe_o,
  output logic we_o,
  output logic drv_o
);

  state_e           state_q;
  logic [CNT_W-1:0] cnt_q;

  assign ready_o   = (state_q == ST_IDLE);
  assign load_o    = ready_o && req_i;
  assign capture_o = (state_q == ST_RD) && (cnt_q == CNT_W'(RD_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      ce_o    <= 1'b0;
      oe_o    <= 1'b0;
      we_o    <= 1'b0;
      drv_o   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_i) begin
            cnt_q <= '0;
            ce_o  <= 1'b1;
            if (we_i) begin
              we_o    <= 1'b1;
              state_q <= ST_WR;
            end else begin
              oe_o    <= 1'b1;
              state_q <= ST_RD;
            end
          end
        end
        ST_WR: begin
          cnt_q <= cnt_q + 1'b1;
          // wait out memory turn-off before driving
          if (cnt_q == CNT_W'(HZ_CYC - 1)) drv_o <= 1'b1;
          if (cnt_q == CNT_W'(WE_CYC - 1)) begin
            we_o    <= 1'b0;
            cnt_q   <= '0;
            state_q <= ST_WEND;
          end
        end
        ST_WEND: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(END_CYC - 1)) begin
            ce_o    <= 1'b0;
            drv_o   <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        ST_RD: begin
          cnt_q <= cnt_q + 1'b1;
          if (capture_o) begin
            ce_o    <= 1'b0;
            oe_o    <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sram_ctrl_dpath.sv
module sram_ctrl_dpath #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] dq_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o   <= '0;
      dq_o     <= '0;
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= capture_i;
      if (load_i) begin
        addr_o <= addr_i;
        dq_o   <= wdata_i;
      end
      if (capture_i) rdata_o <= dq_i;
    end
  end

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned SPEED_NS = 15,
  parameter int unsigned CLK_NS   = 10,
  parameter int unsigned ADDR_W   = 15,
  parameter int unsigned DATA_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic              sram_ce1_no,
  output logic              sram_ce2_o,
  output logic              sram_oe_no,
  output logic              sram_we_no,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe_o,
  input  logic [DATA_W-1:0] sram_dq_i
);

  localparam grade_t      TG      = grade_times(SPEED_NS);
  localparam int unsigned WE_CYC  = we_cycles(TG, CLK_NS);
  localparam int unsigned END_CYC = end_cycles(TG, CLK_NS);
  localparam int unsigned RD_CYC  = rd_cycles(TG, CLK_NS);
  localparam int unsigned HZ_CYC  = ns2cyc(TG.hz, CLK_NS);
  localparam int unsigned MAX_CYC = max2(max2(WE_CYC, END_CYC), RD_CYC);
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  logic load, capture, ce, oe, we, drv;

  sram_ctrl_seq #(
    .WE_CYC (WE_CYC),
    .END_CYC(END_CYC),
    .RD_CYC (RD_CYC),
    .HZ_CYC (HZ_CYC),
    .CNT_W  (CNT_W)
  ) i_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .we_i     (we_i),
    .ready_o  (ready_o),
    .load_o   (load),
    .capture_o(capture),
    .ce_o     (ce),
    .oe_o     (oe),
    .we_o     (we),
    .drv_o    (drv)
  );

  sram_ctrl_dpath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) i_dpath (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .capture_i(capture),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .dq_i     (sram_dq_i),
    .addr_o   (sram_addr_o),
    .dq_o     (sram_dq_o),
    .rdata_o  (rdata_o),
    .rvalid_o (rvalid_o)
  );

  assign sram_ce1_no  = ~ce;
  assign sram_ce2_o   = ce;
  assign sram_oe_no   = ~oe;
  assign sram_we_no   = ~we;
  assign sram_dq_oe_o = drv;

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned SPEED_NS = 15,
  parameter int unsigned CLK_NS   = 10,
  parameter int unsigned ADDR_W   = 15
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              ready_o,
  input logic              rvalid_o,
  input logic [ADDR_W-1:0] sram_addr_o,
  input logic              sram_ce1_no,
  input logic              sram_ce2_o,
  input logic              sram_oe_no,
  input logic              sram_we_no,
  input logic              sram_dq_oe_o
);

  localparam int unsigned WE_CYC = we_cycles(grade_times(SPEED_NS), CLK_NS);

  int unsigned we_low_cnt;
  logic        sel;

  assign sel = !sram_ce1_no && sram_ce2_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) we_low_cnt <= 0;
    else if (!sram_we_no) we_low_cnt <= we_low_cnt + 1;
    else we_low_cnt <= 0;
  end

  assert_busy_needs_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ready_o) |-> $past(req_i));

  assert_we_inside_enables_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |-> sel);

  assert_enables_outlast_we_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_no) |-> sel);

  assert_we_pulse_len_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_no) |-> (we_low_cnt == WE_CYC));

  assert_no_drive_at_we_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sram_we_no) |-> !sram_dq_oe_o);

  assert_no_drive_with_oe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_dq_oe_o |-> sram_oe_no);

  assert_oe_off_in_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |-> sram_oe_no);

  assert_rvalid_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o);

  assert_addr_held_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel && $past(sel)) |-> $stable(sram_addr_o));

endmodule

bind sram_ctrl sram_ctrl_chk #(
  .SPEED_NS(SPEED_NS),
  .CLK_NS  (CLK_NS),
  .ADDR_W  (ADDR_W)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .ready_o     (ready_o),
  .rvalid_o    (rvalid_o),
  .sram_addr_o (sram_addr_o),
  .sram_ce1_no (sram_ce1_no),
  .sram_ce2_o  (sram_ce2_o),
  .sram_oe_no  (sram_oe_no),
  .sram_we_no  (sram_we_no),
  .sram_dq_oe_o(sram_dq_oe_o)
);

// File: tb/test_sram_ctrl.sv
module test_sram_ctrl;

  localparam int AW = 8;
  localparam int DW = 8;
  // grade 15 at 10 ns: strobe 2, busy write 3, read 2, data-ready age 2
  localparam int EXP_WE   = 2;
  localparam int EXP_WBSY = 3;
  localparam int EXP_RD   = 2;
  localparam int RD_NEED  = 2;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          ready, rvalid;
  logic [DW-1:0] rdata;
  logic [AW-1:0] s_addr;
  logic          ce1_n, ce2, oe_n, we_n, dq_oe;
  logic [DW-1:0] dq_o, dq_bus;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sram_ctrl #(.SPEED_NS(15), .CLK_NS(10), .ADDR_W(AW), .DATA_W(DW)) i_sram_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .ready_o(ready), .rdata_o(rdata), .rvalid_o(rvalid),
    .sram_addr_o(s_addr), .sram_ce1_no(ce1_n), .sram_ce2_o(ce2),
    .sram_oe_no(oe_n), .sram_we_no(we_n), .sram_dq_o(dq_o),
    .sram_dq_oe_o(dq_oe), .sram_dq_i(dq_bus)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  // memory model and scoreboard
  logic [DW-1:0] mem [256];
  logic [DW-1:0] sb  [256];
  int            rd_age = 0;
  logic [AW-1:0] age_addr = '0;
  logic          mem_drv;
  int cont_v = 0, ovl_v = 0, oe_v = 0, addr_v = 0, early_v = 0;
  int we_cnt = 0, sd_cnt = 0;
  bit prev_w = 0, prev_sel = 0;
  logic [AW-1:0] prev_addr = '0;
  logic [DW-1:0] wlatch = '0;

  assign mem_drv = !ce1_n && ce2 && !oe_n && we_n;
  assign dq_bus  = dq_oe ? dq_o : mem_drv ? ((rd_age >= RD_NEED) ? mem[s_addr] : ~mem[s_addr]) : 'z;

  initial for (int i = 0; i < 256; i++) begin
    mem[i] = 8'(i) ^ 8'h5a;
    sb[i]  = 8'(i) ^ 8'h5a;
  end

  always @(negedge clk) if (rst_ni) begin
    bit sel, wact;
    sel  = !ce1_n && ce2;
    wact = sel && !we_n;
    if (!we_n && !sel) ovl_v++;
    if (!we_n && !oe_n) oe_v++;
    if (dq_oe && mem_drv) cont_v++;
    if (sel && prev_sel && s_addr != prev_addr) addr_v++;
    if (wact) begin
      if (we_cnt == 0 && dq_oe) early_v++;
      we_cnt++;
      if (dq_oe) begin sd_cnt++; wlatch = dq_o; end
    end else if (prev_w) begin
      chk(we_cnt == EXP_WE, "R4 strobe width", we_cnt, EXP_WE);
      chk(sd_cnt >= 1, "R5 data setup", sd_cnt, 1);
      mem[s_addr] = wlatch;
      we_cnt = 0;
      sd_cnt = 0;
    end
    if (mem_drv) begin
      rd_age   <= (rd_age != 0 && s_addr == age_addr) ? rd_age + 1 : 1;
      age_addr <= s_addr;
    end else rd_age <= 0;
    prev_w    = wact;
    prev_sel  = sel;
    prev_addr = s_addr;
  end

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, output int busy);
    @(negedge clk);
    while (!ready) @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    req = 0;
    busy = 0;
    while (!ready) begin busy++; @(negedge clk); end
    sb[a] = d;
  endtask

  task automatic do_read(input logic [AW-1:0] a, output logic [DW-1:0] d, output int lat, output bit rdy);
    @(negedge clk);
    while (!ready) @(negedge clk);
    req = 1; we = 0; addr = a;
    @(negedge clk);
    req = 0;
    lat = 0;
    while (!rvalid && lat < 20) begin lat++; @(negedge clk); end
    d = rdata;
    rdy = ready;
    @(negedge clk);
    chk(!rvalid, "R7 rvalid single", rvalid, 0);
  endtask

  task automatic read_check(input logic [AW-1:0] a, input string rq);
    logic [DW-1:0] d;
    int lat;
    bit rdy;
    do_read(a, d, lat, rdy);
    chk(d == sb[a], rq, d, sb[a]);
  endtask

  task automatic t_reset;
    chk({ce1_n, ce2, oe_n, we_n, dq_oe, ready, rvalid} == 7'b1011010, "R1 in reset",
        {ce1_n, ce2, oe_n, we_n, dq_oe, ready, rvalid}, 7'b1011010);
    rst_ni = 1;
    repeat (2) @(negedge clk);
    chk({ce1_n, ce2, oe_n, we_n, dq_oe, ready, rvalid} == 7'b1011010, "R1 after reset",
        {ce1_n, ce2, oe_n, we_n, dq_oe, ready, rvalid}, 7'b1011010);
  endtask

  task automatic t_basic;
    int busy, lat;
    bit rdy;
    logic [DW-1:0] d;
    do_write(8'h10, 8'h3c, busy);
    chk(busy == EXP_WBSY, "R8 write busy", busy, EXP_WBSY);
    do_read(8'h10, d, lat, rdy);
    chk(lat == EXP_RD, "R9 read busy", lat, EXP_RD);
    chk(rdy, "R9 ready with rvalid", rdy, 1);
    chk(d == 8'h3c, "R7 read data", d, 8'h3c);
  endtask

  task automatic t_patterns;
    logic [AW-1:0] al [4] = '{8'h00, 8'hff, 8'h01, 8'h80};
    logic [DW-1:0] dl [4] = '{8'h00, 8'hff, 8'ha5, 8'h5a};
    int busy;
    for (int i = 0; i < 4; i++) do_write(al[i], dl[i], busy);
    for (int i = 0; i < 4; i++) read_check(al[i], "R7 pattern readback");
    read_check(8'h42, "R7 untouched location");
  endtask

  task automatic t_busy_ignore;
    int busy;
    @(negedge clk);
    while (!ready) @(negedge clk);
    req = 1; we = 1; addr = 8'h20; wdata = 8'h11;
    @(negedge clk);
    // held request with new target while busy
    addr = 8'h21; wdata = 8'h99;
    chk(!ready, "R2 busy during write", ready, 0);
    @(negedge clk);
    @(negedge clk);
    req = 0;
    busy = 0;
    while (!ready) begin busy++; @(negedge clk); end
    sb[8'h20] = 8'h11;
    read_check(8'h21, "R2 ignored request left memory");
    read_check(8'h20, "R2 accepted write");
    do_write(8'h22, 8'h77, busy);
  endtask

  task automatic t_back_to_back;
    logic [DW-1:0] d;
    int busy, lat;
    bit rdy;
    do_write(8'h30, 8'hc3, busy);
    do_read(8'h30, d, lat, rdy);
    chk(d == 8'hc3, "R7 read after write", d, 8'hc3);
    do_write(8'h30, 8'h3c, busy);
    chk(busy == EXP_WBSY, "R8 write after read", busy, EXP_WBSY);
    do_read(8'h30, d, lat, rdy);
    chk(d == 8'h3c, "R5 turnaround write data", d, 8'h3c);
  endtask

  task automatic t_model_rules;
    chk(ovl_v == 0, "R3 strobe outside enables", ovl_v, 0);
    chk(cont_v == 0, "R5 bus contention", cont_v, 0);
    chk(early_v == 0, "R5 drive at strobe fall", early_v, 0);
    chk(oe_v == 0, "R6 output enable in write", oe_v, 0);
    chk(addr_v == 0, "R10 address moved while selected", addr_v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_basic();
    t_patterns();
    t_busy_ignore();
    t_back_to_back();
    repeat (3) @(negedge clk);
    t_model_rules();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule